// File: doc/BRIEF.md
# Byte-Masked Burst Write Collector

This block sits between a write port and a small line store. A single write select held on one clock edge starts a burst. The write address is taken on that edge. Over the next two cycles the port delivers four data words, two per cycle: an even beat and an odd beat. Each word has its own pair of byte-write selects. When the last pair of words arrives, the collector presents one commit toward the store. The commit carries the address, the 72-bit line with disabled lanes cleared, and an 8-bit lane mask. The store then replaces only the enabled 9-bit lanes of that location.

A new burst may start every other cycle, and a start in the cycle right after an accepted start is dropped. The store has a combinational lookup port that always returns the newest view of a location. That view lays the committing line over the stored line, and then lays the captured first half of an in-flight burst over that result, so a reader never sees stale bytes.

Top module: `burst_write_collector`

## Requirements
- R1: A write is accepted when `wr_sel` is high on a clock edge and no write was accepted on the edge before. A write accepted in cycle c produces `cm_valid` high in cycle c+3, for exactly one cycle, with `cm_addr` equal to the accepted address.
- R2: Words 0 and 1 are taken from `wr_data_e` and `wr_data_o` in cycle c+1. Words 2 and 3 are taken from the same ports in cycle c+2. Word k occupies `cm_data[18k+17:18k]`.
- R3: Each word has two byte selects. Bit 0 covers bits [8:0] of the word and bit 1 covers bits [17:9]. The select for byte b of word k appears as `cm_mask[2k+b]`. In the commit, every byte whose select is low reads as zero.
- R4: After a commit, the addressed location holds the new byte wherever the mask bit is 1 and keeps its old byte wherever the mask bit is 0. This is seen on `rd_data` from cycle c+4.
- R5: A `wr_sel` in the cycle right after an accepted write is ignored. It causes no commit and does not change the address of the burst in progress.
- R6: With `wr_sel` held high continuously, writes are accepted every other cycle and commits appear every other cycle.
- R7: While no burst is in progress, the data and byte-select inputs are ignored: no commit occurs and stored contents do not change.
- R8: In cycle c+3, `rd_data` for the committing address already shows the merged line.
- R9: In cycle c+2, `rd_data` for the address of the burst in progress shows the enabled bytes of words 0 and 1 laid over the older contents.
- R10: After reset, `cm_valid` is low and every location reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_sel | input | 1 | Write start request |
| wr_addr | input | ADDR_W | Write address, taken with an accepted start |
| wr_data_e | input | 18 | Even beat word (word 0 or 2) |
| wr_be_e | input | 2 | Byte selects for the even beat |
| wr_data_o | input | 18 | Odd beat word (word 1 or 3) |
| wr_be_o | input | 2 | Byte selects for the odd beat |
| cm_valid | output | 1 | Commit strobe toward the store |
| cm_addr | output | ADDR_W | Commit address |
| cm_data | output | 72 | Collected line, disabled lanes zero |
| cm_mask | output | 8 | Lane enables of the commit |
| rd_addr | input | ADDR_W | Lookup address |
| rd_data | output | 72 | Newest contents of the lookup address |

## Verification
The bench targets a start request that arrives one cycle after an accepted start. A design that re-armed too early would emit a second commit or take the second address. It holds the select high for several cycles to see that commits alternate, rather than bunching up or stalling. Partial masks are written over locations that already hold data. A collector that wrote whole lines, or swapped lane and beat order, would corrupt bytes that should survive. Lookups in the two cycles before the store updates expose a forwarding path that returns stale data or skips the half-captured burst.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int BYTE_W   = 9;
  localparam int LANES    = 2;
  localparam int BEATS    = 4;
  localparam int PER_CYC  = 2;
  localparam int WORD_W   = BYTE_W * LANES;
  localparam int LINE_W   = WORD_W * BEATS;
  localparam int MASK_W   = LANES * BEATS;
  localparam int HALF_W   = WORD_W * PER_CYC;
  localparam int HALF_M   = LANES * PER_CYC;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [MASK_W-1:0] mask_t;

  // widen one enable bit per byte lane into a full bit mask
  function automatic line_t lane_bits(input mask_t m);
    line_t r;
    for (int i = 0; i < MASK_W; i++) r[i*BYTE_W +: BYTE_W] = {BYTE_W{m[i]}};
    return r;
  endfunction

  // replace only the enabled lanes of old with those of nw
  function automatic line_t merge_line(input line_t old, input line_t nw, input mask_t m);
    line_t lb;
    lb = lane_bits(m);
    return (old & ~lb) | (nw & lb);
  endfunction
endpackage

// File: rtl/bwc_accept.sv
module bwc_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_sel,
  output logic ev_accept,
  output logic in_lo,
  output logic in_hi
);
  logic lo_q, hi_q;

  // a start on the edge after an accepted start is dropped
  assign ev_accept = wr_sel & ~lo_q;
  assign in_lo     = lo_q;
  assign in_hi     = hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else begin
      lo_q <= ev_accept;
      hi_q <= lo_q;
    end
  end
endmodule

// File: rtl/bwc_gather.sv
module bwc_gather
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_accept,
  input  logic              in_lo,
  input  logic              in_hi,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data_e,
  input  logic [LANES-1:0]  wr_be_e,
  input  logic [WORD_W-1:0] wr_data_o,
  input  logic [LANES-1:0]  wr_be_o,
  output logic [ADDR_W-1:0] col_addr,
  output logic [HALF_W-1:0] hold_data,
  output logic [HALF_M-1:0] hold_mask,
  output logic              cm_valid,
  output logic [ADDR_W-1:0] cm_addr,
  output line_t             cm_data,
  output mask_t             cm_mask
);
  mask_t full_mask;
  line_t full_data;

  assign full_mask = {wr_be_o, wr_be_e, hold_mask};
  assign full_data = {wr_data_o, wr_data_e, hold_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_addr  <= '0;
      hold_data <= '0;
      hold_mask <= '0;
      cm_valid  <= 1'b0;
      cm_addr   <= '0;
      cm_data   <= '0;
      cm_mask   <= '0;
    end else begin
      cm_valid <= in_hi;
      if (ev_accept) col_addr <= wr_addr;
      if (in_lo) begin
        hold_data <= {wr_data_o, wr_data_e};
        hold_mask <= {wr_be_o, wr_be_e};
      end
      if (in_hi) begin
        cm_addr <= col_addr;
        cm_mask <= full_mask;
        cm_data <= full_data & lane_bits(full_mask);
      end
    end
  end
endmodule

// File: rtl/bwc_store.sv
module bwc_store
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cm_valid,
  input  logic [ADDR_W-1:0] cm_addr,
  input  line_t             cm_data,
  input  mask_t             cm_mask,
  input  logic              part_valid,
  input  logic [ADDR_W-1:0] col_addr,
  input  logic [HALF_W-1:0] hold_data,
  input  logic [HALF_M-1:0] hold_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output line_t             rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  line_t mem [DEPTH];
  line_t stage1;
  line_t part_line;
  mask_t part_mask;

  assign part_line = {{(LINE_W-HALF_W){1'b0}}, hold_data};
  assign part_mask = {{(MASK_W-HALF_M){1'b0}}, hold_mask};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (cm_valid) begin
      mem[cm_addr] <= merge_line(mem[cm_addr], cm_data, cm_mask);
    end
  end

  // newest first: half-collected burst over committing line over stored line
  always_comb begin
    stage1 = mem[rd_addr];
    if (cm_valid && cm_addr == rd_addr) stage1 = merge_line(stage1, cm_data, cm_mask);
    rd_data = stage1;
    if (part_valid && col_addr == rd_addr) rd_data = merge_line(stage1, part_line, part_mask);
  end
endmodule

// File: rtl/burst_write_collector.sv
module burst_write_collector
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [17:0]       wr_data_e,
  input  logic [1:0]        wr_be_e,
  input  logic [17:0]       wr_data_o,
  input  logic [1:0]        wr_be_o,
  output logic              cm_valid,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [71:0]       cm_data,
  output logic [7:0]        cm_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [71:0]       rd_data
);
  logic              ev_accept, in_lo, in_hi;
  logic [ADDR_W-1:0] col_addr;
  logic [HALF_W-1:0] hold_data;
  logic [HALF_M-1:0] hold_mask;

  bwc_accept u_accept (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel),
    .ev_accept(ev_accept), .in_lo(in_lo), .in_hi(in_hi)
  );

  bwc_gather #(.ADDR_W(ADDR_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .ev_accept(ev_accept), .in_lo(in_lo), .in_hi(in_hi),
    .wr_addr(wr_addr), .wr_data_e(wr_data_e), .wr_be_e(wr_be_e),
    .wr_data_o(wr_data_o), .wr_be_o(wr_be_o),
    .col_addr(col_addr), .hold_data(hold_data), .hold_mask(hold_mask),
    .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data), .cm_mask(cm_mask)
  );

  bwc_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cm_valid(cm_valid), .cm_addr(cm_addr),
    .cm_data(cm_data), .cm_mask(cm_mask), .part_valid(in_hi), .col_addr(col_addr),
    .hold_data(hold_data), .hold_mask(hold_mask), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker
  import bwc_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  ev_accept,
  input logic  in_lo,
  input logic  in_hi,
  input logic  cm_valid,
  input line_t cm_data,
  input mask_t cm_mask
);
  a_r1_commit_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> ##3 cm_valid);
  a_r5_no_back_to_back_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !ev_accept);
  a_r2_second_half_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_lo |=> in_hi);
  a_r6_single_cycle_commit: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |=> !cm_valid);
  a_r7_commit_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> $past(in_hi));
  a_r3_disabled_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> ((cm_data & ~lane_bits(cm_mask)) == '0));
endmodule

bind burst_write_collector bwc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ev_accept(ev_accept), .in_lo(in_lo), .in_hi(in_hi),
  .cm_valid(cm_valid), .cm_data(cm_data), .cm_mask(cm_mask)
);

// File: tb/burst_write_collector_tb.sv
module burst_write_collector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_sel = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [17:0] wr_data_e = '0, wr_data_o = '0;
  logic [1:0]  wr_be_e = '0, wr_be_o = '0;
  logic        cm_valid;
  logic [3:0]  cm_addr;
  logic [71:0] cm_data;
  logic [7:0]  cm_mask;
  logic [3:0]  rd_addr = '0;
  logic [71:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [71:0] model [16];

  always #5 clk = ~clk;

  burst_write_collector u_dut (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data_e(wr_data_e), .wr_be_e(wr_be_e), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o),
    .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data), .cm_mask(cm_mask),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // vector: [83:80] address, [79:8] words {w3,w2,w1,w0}, [7:0] lane mask
  localparam logic [83:0] VEC [6] = '{
    {4'd3, 18'h3FFFF, 18'h12345, 18'h2ABCD, 18'h00F0F, 8'hFF},
    {4'd3, 18'h00000, 18'h11111, 18'h22222, 18'h33333, 8'h5A},
    {4'd7, 18'h1C0DE, 18'h0BEEF, 18'h3A5A5, 18'h15555, 8'h81},
    {4'd7, 18'h2F00D, 18'h0CAFE, 18'h01234, 18'h3FEDC, 8'h3C},
    {4'd0, 18'h2AAAA, 18'h15555, 18'h0F0F0, 18'h30303, 8'hC3},
    {4'd3, 18'h3CCCC, 18'h03333, 18'h1E1E1, 18'h21212, 8'h00}
  };

  function automatic logic [71:0] keep_enabled(input logic [71:0] d, input logic [7:0] m);
    logic [71:0] r = '0;
    for (int b = 0; b < 8; b++)
      if (m[b]) for (int j = 0; j < 9; j++) r[b*9+j] = d[b*9+j];
    return r;
  endfunction

  function automatic logic [71:0] overlay(input logic [71:0] o, input logic [71:0] n, input logic [7:0] m);
    logic [71:0] r = o;
    for (int b = 0; b < 8; b++)
      if (m[b]) for (int j = 0; j < 9; j++) r[b*9+j] = n[b*9+j];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr_sel = 1'b0;
    wr_data_e = 18'h2DEAD; wr_data_o = 18'h1BEEF; wr_be_e = 2'b11; wr_be_o = 2'b11;
  endtask

  task automatic put_beats(input logic [17:0] we, input logic [1:0] me,
                           input logic [17:0] wo, input logic [1:0] mo);
    wr_data_e = we; wr_be_e = me; wr_data_o = wo; wr_be_o = mo;
  endtask

  // one isolated burst from the vector table, with commit and forwarding checks
  task automatic run_vec(input logic [83:0] v);
    logic [3:0]  a = v[83:80];
    logic [71:0] d = v[79:8];
    logic [7:0]  m = v[7:0];
    logic [71:0] merged;
    tick(); wr_sel = 1'b1; wr_addr = a;
    tick(); wr_sel = 1'b0; wr_addr = ~a;
    put_beats(d[17:0], m[1:0], d[35:18], m[3:2]);
    tick(); put_beats(d[53:36], m[5:4], d[71:54], m[7:6]); rd_addr = a; #1;
    chk(rd_data == overlay(model[a], {36'h0, d[35:0]}, {4'h0, m[3:0]}), "R9 half forward",
        {8'h0, rd_data}, {8'h0, overlay(model[a], {36'h0, d[35:0]}, {4'h0, m[3:0]})});
    tick(); idle_inputs(); #1;
    merged = overlay(model[a], d, m);
    chk(cm_valid === 1'b1 && cm_addr == a, "R1 commit strobe/addr",
        {75'h0, cm_valid, cm_addr}, {75'h0, 1'b1, a});
    chk(cm_data == keep_enabled(d, m), "R2 R3 commit data", {8'h0, cm_data}, {8'h0, keep_enabled(d, m)});
    chk(cm_mask == m, "R3 commit mask", {72'h0, cm_mask}, {72'h0, m});
    chk(rd_data == merged, "R8 commit forward", {8'h0, rd_data}, {8'h0, merged});
    tick(); #1;
    model[a] = merged;
    chk(cm_valid === 1'b0, "R1 one-cycle strobe", {79'h0, cm_valid}, 80'h0);
    chk(rd_data == merged, "R4 masked merge stored", {8'h0, rd_data}, {8'h0, merged});
  endtask

  initial begin
    #(10 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n_commit;
    for (int i = 0; i < 16; i++) model[i] = '0;
    idle_inputs();
    repeat (3) tick();
    #1;
    chk(cm_valid === 1'b0, "R10 reset strobe", {79'h0, cm_valid}, 80'h0);
    for (int i = 0; i < 16; i += 5) begin
      rd_addr = i[3:0]; #1;
      chk(rd_data == '0, "R10 reset contents", {8'h0, rd_data}, 80'h0);
    end
    tick(); rst_n = 1'b1;
    tick();

    for (int k = 0; k < 6; k++) run_vec(VEC[k]);

    // R5: start request one cycle after an accepted start is dropped
    tick(); wr_sel = 1'b1; wr_addr = 4'd9;
    tick(); wr_sel = 1'b1; wr_addr = 4'd10; put_beats(18'h00111, 2'b11, 18'h00222, 2'b11);
    tick(); wr_sel = 1'b0; put_beats(18'h00333, 2'b11, 18'h00444, 2'b11);
    n_commit = 0;
    for (int c = 0; c < 5; c++) begin
      tick(); idle_inputs(); #1;
      if (cm_valid) begin
        n_commit++;
        chk(cm_addr == 4'd9, "R5 surviving address", {76'h0, cm_addr}, {76'h0, 4'd9});
      end
    end
    model[9] = {18'h00444, 18'h00333, 18'h00222, 18'h00111};
    chk(n_commit == 1, "R5 single commit", 80'(n_commit), 80'd1);
    rd_addr = 4'd10; #1;
    chk(rd_data == model[10], "R5 dropped address untouched", {8'h0, rd_data}, {8'h0, model[10]});

    // R6: select held high, accepts at cycles 0 and 2 only
    tick(); wr_sel = 1'b1; wr_addr = 4'd12;
    tick(); wr_addr = 4'd13; put_beats(18'h0A001, 2'b11, 18'h0A002, 2'b11);
    tick(); wr_addr = 4'd14; put_beats(18'h0A003, 2'b11, 18'h0A004, 2'b11);
    tick(); wr_addr = 4'd15; put_beats(18'h0B001, 2'b01, 18'h0B002, 2'b10); #1;
    chk(cm_valid === 1'b1 && cm_addr == 4'd12, "R6 first commit", {75'h0, cm_valid, cm_addr}, {75'h0, 1'b1, 4'd12});
    tick(); wr_sel = 1'b0; put_beats(18'h0B003, 2'b11, 18'h0B004, 2'b00); #1;
    chk(cm_valid === 1'b0, "R6 gap cycle", {79'h0, cm_valid}, 80'h0);
    tick(); idle_inputs(); #1;
    chk(cm_valid === 1'b1 && cm_addr == 4'd14, "R6 second commit", {75'h0, cm_valid, cm_addr}, {75'h0, 1'b1, 4'd14});
    tick(); #1;
    chk(cm_valid === 1'b0, "R6 no third commit", {79'h0, cm_valid}, 80'h0);
    model[12] = {18'h0A004, 18'h0A003, 18'h0A002, 18'h0A001};
    model[14] = overlay(model[14], {18'h0B004, 18'h0B003, 18'h0B002, 18'h0B001}, 8'b00_11_10_01);
    rd_addr = 4'd14; #1;
    chk(rd_data == model[14], "R6 R3 second line", {8'h0, rd_data}, {8'h0, model[14]});
    rd_addr = 4'd13; #1;
    chk(rd_data == model[13], "R6 skipped address", {8'h0, rd_data}, {8'h0, model[13]});

    // R7: beats without a burst are ignored
    rd_addr = 4'd3;
    for (int c = 0; c < 4; c++) begin
      tick(); wr_sel = 1'b0; wr_addr = 4'd3; put_beats(18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11); #1;
      chk(cm_valid === 1'b0, "R7 no commit when idle", {79'h0, cm_valid}, 80'h0);
    end
    tick(); idle_inputs(); #1;
    chk(rd_data == model[3], "R7 contents unchanged", {8'h0, rd_data}, {8'h0, model[3]});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule